// File: doc/BRIEF.md
# Strided Block Mover Between Local Banks and External Memory

The block moves rectangular data between two small on-chip banks (an instruction bank and a data bank, each `BANK_BYTES` wide) and a larger external memory. Software first loads a local start address and an external start address; these only sit in pending registers. A write to one of two length registers then starts the move. The read-length register copies from external memory into a local bank, and the write-length register copies from a local bank out to external memory. One packed length word describes the whole shape: the bytes in each row, the number of rows, and the gap skipped in external memory between rows.

The engine moves one 64-bit word per clock. Local offsets wrap to the start of the selected bank, so a row can cross the bank end. On reads, external addresses at or past `EXT_BYTES` return zero into local memory. On writes, words aimed there are dropped. When the move ends, the engine publishes the final local and external addresses and sets both length registers to a spent value.

Top module: `strided_dma`

## Requirements
- R1: The length word decodes as follows. Bits 11:3 give the row length in 8-byte words minus one, so bits 2:0 are ignored. Bits 19:12 give the row count minus one. Bits 27:23 give the inter-row skip in 8-byte words. Bits 22:20 and 31:28 do not affect the shape.
- R2: Local address bit 12 selects the bank (1 = instruction bank, driven as `lcl_bank`=1; 0 = data bank). Bits 11:3 give the starting word index. Bits 2:0 and bits above 12 are ignored.
- R3: The external start address uses only bits 23:3; `ext_addr` carries the word address (byte address divided by 8).
- R4: The local word index increments by one per word and wraps from the last word of the bank to index 0 within the same bank.
- R5: On a read, a word whose external byte address is at or beyond `EXT_BYTES` is written into local memory as zero, and no external request is issued for it.
- R6: On a write, a word whose external byte address is at or beyond `EXT_BYTES` is dropped: no external request or write strobe is issued for it.
- R7: The external address increments by one word per word moved, plus the skip after every row except the last. The reported final external address is start + rows*rowlen + (rows-1)*skip, in bytes, modulo 2^24.
- R8: At completion, `lcl_addr_o` holds the bank bit in bit 12 and, in bits 11:0, the byte offset that follows the last word moved (modulo bank size).
- R9: While a move runs, the started length register reads back the word that was written. At completion, both length registers read {started word bits 31:23, 11 zero bits, 12'hFF8}.
- R10: `busy_o` rises at the clock edge that accepts a length write. It stays high for exactly rows*rowlen-in-words cycles, one word per cycle.
- R11: Writes to the address registers only update the pending values. They start no move and leave `lcl_addr_o` and `ext_addr_o` unchanged; the next move starts from them.
- R12: A length-register write while `busy_o` is high is ignored. It changes no length register and starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 local addr, 1 external addr, 2 read length, 3 write length |
| cfg_wdata | input | 32 | Register write data |
| lcl_addr_o | output | 13 | Reported local address |
| ext_addr_o | output | 24 | Reported external address |
| rd_len_o | output | 32 | Read-length register |
| wr_len_o | output | 32 | Write-length register |
| busy_o | output | 1 | Move in progress |
| lcl_en | output | 1 | Local bank access this cycle |
| lcl_we | output | 1 | Local bank write |
| lcl_bank | output | 1 | 1 = instruction bank, 0 = data bank |
| lcl_idx | output | 9 | Local word index |
| lcl_wdata | output | 64 | Local write data |
| lcl_rdata | input | 64 | Local read data, same-cycle |
| ext_req | output | 1 | External access this cycle |
| ext_we | output | 1 | External write |
| ext_addr | output | 21 | External word address |
| ext_wdata | output | 64 | External write data |
| ext_rdata | input | 64 | External read data, same-cycle |

## Verification
A wrong row or word counter changes how long `busy_o` stays high, so it shows in the first move it affects. It also shows when the move ends, in the published addresses, which are off by whole words. A broken wrap or skip puts data at the wrong bank or external words, and the bench finds it when it compares memory after the move. A faulty range guard shows up at once: a stray external strobe past the mapped size, or a non-zero word where a zero fill was due.

// File: rtl/strided_dma_pkg.sv
package strided_dma_pkg;

   typedef enum logic [1:0] {
      CSEL_LCL  = 2'd0,
      CSEL_EXT  = 2'd1,
      CSEL_RLEN = 2'd2,
      CSEL_WLEN = 2'd3
   } csel_e;

   typedef struct packed {
      logic [8:0] row_m1;   // words per row minus one
      logic [7:0] rows_m1;  // rows minus one
      logic [4:0] skip;     // words skipped between rows
   } shape_t;

   function automatic shape_t decode_shape(input logic [31:0] w);
      shape_t s;
      s.row_m1  = w[11:3];
      s.rows_m1 = w[19:12];
      s.skip    = w[27:23];
      return s;
   endfunction

endpackage

// File: rtl/strided_dma_cfg.sv
module strided_dma_cfg
   import strided_dma_pkg::*;
#(
   parameter int LCL_AW = 13,
   parameter int EXT_AW = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_sel,
   input  logic [31:0]       cfg_wdata,
   input  logic              busy,
   input  logic              done,
   input  logic [LCL_AW-1:0] fin_lcl,
   input  logic [EXT_AW-1:0] fin_ext,
   output logic              start,
   output logic              start_dir,
   output shape_t            start_shape,
   output logic [LCL_AW-4:0] pend_lcl,
   output logic [EXT_AW-4:0] pend_ext,
   output logic [31:0]       rd_len,
   output logic [31:0]       wr_len,
   output logic [LCL_AW-1:0] rep_lcl,
   output logic [EXT_AW-1:0] rep_ext
);

   csel_e      sel;
   logic       is_len;
   logic [8:0] act_hi;

   assign sel         = csel_e'(cfg_sel);
   assign is_len      = cfg_we && (sel == CSEL_RLEN || sel == CSEL_WLEN);
   assign start       = is_len && !busy;
   assign start_dir   = (sel == CSEL_WLEN);
   assign start_shape = decode_shape(cfg_wdata);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_lcl <= '0;
         pend_ext <= '0;
         rd_len   <= '0;
         wr_len   <= '0;
         rep_lcl  <= '0;
         rep_ext  <= '0;
         act_hi   <= '0;
      end else begin
         if (cfg_we && sel == CSEL_LCL) pend_lcl <= cfg_wdata[LCL_AW-1:3];
         if (cfg_we && sel == CSEL_EXT) pend_ext <= cfg_wdata[EXT_AW-1:3];
         if (start) begin
            act_hi <= cfg_wdata[31:23];
            if (start_dir) wr_len <= cfg_wdata;
            else           rd_len <= cfg_wdata;
         end
         if (done) begin
            rd_len  <= {act_hi, 11'd0, 12'hFF8};
            wr_len  <= {act_hi, 11'd0, 12'hFF8};
            rep_lcl <= fin_lcl;
            rep_ext <= fin_ext;
         end
      end
   end

   // R12: a length write during a running move leaves both length registers alone
   assert_len_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done && is_len) |=> ($stable(rd_len) && $stable(wr_len)));

   // R11: address writes never touch the reported addresses
   assert_addr_pending_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && !is_len && !done) |=> ($stable(rep_lcl) && $stable(rep_ext)));

   // R9: spent length value after completion
   assert_len_spent_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (rd_len == wr_len && rd_len[11:0] == 12'hFF8 && rd_len[22:12] == 11'd0));

endmodule

// File: rtl/strided_dma_seq.sv
module strided_dma_seq
   import strided_dma_pkg::*;
#(
   parameter int LCL_OFF_W = 12,
   parameter int EXT_AW    = 24
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic                 start_dir,
   input  shape_t               start_shape,
   input  logic [LCL_OFF_W-2:0] pend_lcl,
   input  logic [EXT_AW-4:0]    pend_ext,
   output logic                 busy,
   output logic                 dir,
   output logic                 bank,
   output logic [LCL_OFF_W-4:0] lcl_idx,
   output logic [EXT_AW-4:0]    ext_idx,
   output logic                 done,
   output logic [LCL_OFF_W:0]   fin_lcl,
   output logic [EXT_AW-1:0]    fin_ext
);

   localparam int LIW = LCL_OFF_W - 3;
   localparam int EWW = EXT_AW - 3;

   shape_t         shape_q;
   logic [8:0]     col_q;
   logic [7:0]     rows_left_q;
   logic [LIW-1:0] lidx_nx;
   logic [EWW-1:0] eidx_nx;
   logic [4:0]     skip_w;
   logic           row_end;
   logic           last;

   assign skip_w  = shape_q.skip;
   assign row_end = (col_q == shape_q.row_m1);
   assign last    = row_end && (rows_left_q == 8'd0);
   assign done    = busy && last;
   assign lidx_nx = lcl_idx + LIW'(1);
   assign eidx_nx = ext_idx + EWW'(1);
   assign fin_lcl = {bank, lidx_nx, 3'b000};
   assign fin_ext = {eidx_nx, 3'b000};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy        <= 1'b0;
         dir         <= 1'b0;
         bank        <= 1'b0;
         lcl_idx     <= '0;
         ext_idx     <= '0;
         col_q       <= '0;
         rows_left_q <= '0;
         shape_q     <= '0;
      end else if (start) begin
         busy        <= 1'b1;
         dir         <= start_dir;
         bank        <= pend_lcl[LIW];
         lcl_idx     <= pend_lcl[LIW-1:0];
         ext_idx     <= pend_ext;
         col_q       <= '0;
         rows_left_q <= start_shape.rows_m1;
         shape_q     <= start_shape;
      end else if (busy) begin
         lcl_idx <= lidx_nx;
         if (!row_end) begin
            col_q   <= col_q + 9'd1;
            ext_idx <= eidx_nx;
         end else if (last) begin
            busy    <= 1'b0;
            col_q   <= '0;
            ext_idx <= eidx_nx;
         end else begin
            col_q       <= '0;
            rows_left_q <= rows_left_q - 8'd1;
            ext_idx     <= eidx_nx + EWW'(skip_w);
         end
      end
   end

   // R4: local index steps by one and wraps inside the bank
   assert_local_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !last) |=> (lcl_idx == LIW'($past(lcl_idx) + LIW'(1))));

   // R7: skip is added between rows only
   assert_row_skip_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && row_end && !last) |=>
      (ext_idx == EWW'($past(ext_idx) + EWW'(1) + EWW'($past(skip_w)))));

   // R7: inside a row the external index steps by one word
   assert_in_row_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !row_end) |=> (ext_idx == EWW'($past(ext_idx) + EWW'(1))));

   // R10: the last word ends the busy window
   assert_done_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);

endmodule

// File: rtl/strided_dma_xguard.sv
module strided_dma_xguard #(
   parameter int EXT_AW    = 24,
   parameter int EXT_BYTES = 8388608
) (
   input  logic              beat,
   input  logic              dir,
   input  logic [EXT_AW-4:0] ext_idx,
   input  logic [63:0]       lcl_rdata,
   input  logic [63:0]       ext_rdata,
   output logic              ext_req,
   output logic              ext_we,
   output logic [EXT_AW-4:0] ext_addr,
   output logic [63:0]       ext_wdata,
   output logic              lcl_en,
   output logic              lcl_we,
   output logic [63:0]       lcl_wdata
);

   localparam int EWW  = EXT_AW - 3;
   localparam bit FULL = (longint'(EXT_BYTES) >= (longint'(1) << EXT_AW));

   logic in_range;

   generate
      if (FULL) begin : g_full_map
         assign in_range = 1'b1;
      end else begin : g_bounded
         localparam logic [EWW:0] LIMIT = (EWW+1)'(EXT_BYTES / 8);
         assign in_range = ({1'b0, ext_idx} < LIMIT);
      end
   endgenerate

   assign ext_req   = beat && in_range;
   assign ext_we    = beat && in_range && dir;
   assign ext_addr  = ext_idx;
   assign ext_wdata = lcl_rdata;
   assign lcl_en    = beat;
   assign lcl_we    = beat && !dir;
   assign lcl_wdata = in_range ? ext_rdata : 64'd0;

endmodule

// File: rtl/strided_dma.sv
module strided_dma
   import strided_dma_pkg::*;
#(
   parameter int BANK_BYTES = 4096,
   parameter int EXT_AW     = 24,
   parameter int EXT_BYTES  = 8388608
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            cfg_we,
   input  logic [1:0]                      cfg_sel,
   input  logic [31:0]                     cfg_wdata,
   output logic [$clog2(BANK_BYTES):0]     lcl_addr_o,
   output logic [EXT_AW-1:0]               ext_addr_o,
   output logic [31:0]                     rd_len_o,
   output logic [31:0]                     wr_len_o,
   output logic                            busy_o,
   output logic                            lcl_en,
   output logic                            lcl_we,
   output logic                            lcl_bank,
   output logic [$clog2(BANK_BYTES)-4:0]   lcl_idx,
   output logic [63:0]                     lcl_wdata,
   input  logic [63:0]                     lcl_rdata,
   output logic                            ext_req,
   output logic                            ext_we,
   output logic [EXT_AW-4:0]               ext_addr,
   output logic [63:0]                     ext_wdata,
   input  logic [63:0]                     ext_rdata
);

   localparam int LCL_OFF_W = $clog2(BANK_BYTES);
   localparam int LCL_AW    = LCL_OFF_W + 1;

   initial begin : param_checks
      assert (BANK_BYTES >= 64 && BANK_BYTES <= 4096 && (BANK_BYTES & (BANK_BYTES - 1)) == 0)
         else $error("BANK_BYTES must be a power of two in 64..4096");
      assert (EXT_AW >= 8 && EXT_AW <= 32)
         else $error("EXT_AW out of range");
      assert (EXT_BYTES > 0 && EXT_BYTES % 8 == 0)
         else $error("EXT_BYTES must be a positive multiple of 8");
   end

   logic              start, start_dir, done, beat, dir;
   shape_t            start_shape;
   logic [LCL_AW-4:0] pend_lcl;
   logic [EXT_AW-4:0] pend_ext;
   logic [EXT_AW-4:0] ext_idx;
   logic [LCL_AW-1:0] fin_lcl;
   logic [EXT_AW-1:0] fin_ext;

   strided_dma_cfg #(.LCL_AW(LCL_AW), .EXT_AW(EXT_AW)) u_cfg (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
      .busy(beat), .done(done), .fin_lcl(fin_lcl), .fin_ext(fin_ext),
      .start(start), .start_dir(start_dir), .start_shape(start_shape),
      .pend_lcl(pend_lcl), .pend_ext(pend_ext), .rd_len(rd_len_o), .wr_len(wr_len_o),
      .rep_lcl(lcl_addr_o), .rep_ext(ext_addr_o)
   );

   strided_dma_seq #(.LCL_OFF_W(LCL_OFF_W), .EXT_AW(EXT_AW)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .start_dir(start_dir),
      .start_shape(start_shape), .pend_lcl(pend_lcl), .pend_ext(pend_ext),
      .busy(beat), .dir(dir), .bank(lcl_bank), .lcl_idx(lcl_idx), .ext_idx(ext_idx),
      .done(done), .fin_lcl(fin_lcl), .fin_ext(fin_ext)
   );

   strided_dma_xguard #(.EXT_AW(EXT_AW), .EXT_BYTES(EXT_BYTES)) u_guard (
      .beat(beat), .dir(dir), .ext_idx(ext_idx), .lcl_rdata(lcl_rdata), .ext_rdata(ext_rdata),
      .ext_req(ext_req), .ext_we(ext_we), .ext_addr(ext_addr), .ext_wdata(ext_wdata),
      .lcl_en(lcl_en), .lcl_we(lcl_we), .lcl_wdata(lcl_wdata)
   );

   assign busy_o = beat;

   // R5: a local write with no external fetch must carry zeros
   assert_zero_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (lcl_we && !ext_req) |-> (lcl_wdata == 64'd0));

   // R6: an external write strobe only occurs while reading the local bank
   assert_wr_strobe_dir_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ext_we |-> (lcl_en && !lcl_we && ext_req));

   // R10: no memory traffic outside the busy window
   assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (!lcl_en && !ext_req));

endmodule

// File: tb/strided_dma_tb.sv
module strided_dma_tb;

   localparam int CLK_PERIOD = 10;
   localparam int XW         = 256;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_sel = 2'd0;
   logic [31:0] cfg_wdata = 32'd0;
   logic [12:0] lcl_addr_o;
   logic [23:0] ext_addr_o;
   logic [31:0] rd_len_o, wr_len_o;
   logic        busy_o, lcl_en, lcl_we, lcl_bank;
   logic [8:0]  lcl_idx;
   logic [63:0] lcl_wdata, lcl_rdata, ext_wdata, ext_rdata;
   logic        ext_req, ext_we;
   logic [20:0] ext_addr;

   logic [63:0] imem [512];
   logic [63:0] dmem [512];
   logic [63:0] xmem [XW];
   int          oob_cnt = 0;
   int          ext_wr_cnt = 0;
   int          n_vec = 0;
   int          n_bad = 0;
   bit          finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   strided_dma #(.BANK_BYTES(4096), .EXT_AW(24), .EXT_BYTES(2048)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
      .lcl_addr_o(lcl_addr_o), .ext_addr_o(ext_addr_o), .rd_len_o(rd_len_o),
      .wr_len_o(wr_len_o), .busy_o(busy_o), .lcl_en(lcl_en), .lcl_we(lcl_we),
      .lcl_bank(lcl_bank), .lcl_idx(lcl_idx), .lcl_wdata(lcl_wdata), .lcl_rdata(lcl_rdata),
      .ext_req(ext_req), .ext_we(ext_we), .ext_addr(ext_addr), .ext_wdata(ext_wdata),
      .ext_rdata(ext_rdata)
   );

   function automatic logic [63:0] xpat(input int i);
      return 64'hE000_0000_0000_0000 | (64'(i) * 64'h1_0001);
   endfunction
   function automatic logic [63:0] ipat(input int i);
      return 64'h1100_0000_0000_0000 + 64'(i);
   endfunction
   function automatic logic [63:0] dpat(input int i);
      return 64'hD000_0000_0000_0000 + 64'(i);
   endfunction

   assign lcl_rdata = lcl_bank ? imem[lcl_idx] : dmem[lcl_idx];
   assign ext_rdata = xmem[ext_addr[7:0]];

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 512; i++) begin
            imem[i] <= ipat(i);
            dmem[i] <= dpat(i);
         end
         for (int i = 0; i < XW; i++) xmem[i] <= xpat(i);
      end else begin
         if (lcl_en && lcl_we) begin
            if (lcl_bank) imem[lcl_idx] <= lcl_wdata;
            else          dmem[lcl_idx] <= lcl_wdata;
         end
         if (ext_req && ext_we) begin
            ext_wr_cnt <= ext_wr_cnt + 1;
            if (ext_addr < 21'(XW)) xmem[ext_addr[7:0]] <= ext_wdata;
         end
         if (ext_req && ext_addr >= 21'(XW)) oob_cnt <= oob_cnt + 1;
      end
   end

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic cfg_write(input logic [1:0] sel, input logic [31:0] data);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic count_busy(output int n);
      n = 0;
      while (busy_o && n < 100000) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic t_reset;
      chk("R10 reset busy", 64'(busy_o), 64'd0);
      chk("R8 reset local addr", 64'(lcl_addr_o), 64'd0);
      chk("R7 reset ext addr", 64'(ext_addr_o), 64'd0);
      chk("R9 reset lengths", {rd_len_o, wr_len_o}, 64'd0);
      chk("R10 reset no traffic", 64'({lcl_en, ext_req}), 64'd0);
   endtask

   // Two rows of three words, skip two words, masked junk in the length word
   task automatic t_read_rows;
      int n;
      cfg_write(2'd0, 32'hFFFF_E013);
      cfg_write(2'd1, 32'h0000_0040);
      cfg_write(2'd2, 32'h4110_1015);
      chk("R9 rd len while running", 64'(rd_len_o), 64'h4110_1015);
      count_busy(n);
      chk("R10 R1 busy cycles 2x3", 64'(n), 64'd6);
      for (int k = 0; k < 3; k++) begin
         chk("R1 R2 row0 data", dmem[2 + k], xpat(8 + k));
         chk("R1 R7 row1 data", dmem[5 + k], xpat(13 + k));
      end
      chk("R2 neighbour below untouched", dmem[1], dpat(1));
      chk("R1 neighbour above untouched", dmem[8], dpat(8));
      chk("R7 final ext addr", 64'(ext_addr_o), 64'h80);
      chk("R8 final local addr", 64'(lcl_addr_o), 64'h040);
      chk("R9 rd len spent", 64'(rd_len_o), 64'h4100_0FF8);
      chk("R9 wr len spent", 64'(wr_len_o), 64'h4100_0FF8);
   endtask

   // Instruction bank to external, row crosses the bank end
   task automatic t_write_wrap;
      int n;
      cfg_write(2'd0, 32'h0000_1FF0);
      cfg_write(2'd1, 32'h0000_0100);
      cfg_write(2'd3, 32'h0000_0018);
      chk("R9 wr len while running", 64'(wr_len_o), 64'h18);
      count_busy(n);
      chk("R10 busy cycles 4", 64'(n), 64'd4);
      chk("R4 word at 510", xmem[32], ipat(510));
      chk("R4 word at 511", xmem[33], ipat(511));
      chk("R4 wrapped word 0", xmem[34], ipat(0));
      chk("R4 wrapped word 1", xmem[35], ipat(1));
      chk("R4 next ext untouched", xmem[36], xpat(36));
      chk("R8 R2 final local addr bank kept", 64'(lcl_addr_o), 64'h1010);
      chk("R7 final ext addr", 64'(ext_addr_o), 64'h120);
      chk("R9 both lengths spent", {rd_len_o, wr_len_o}, {32'h0000_0FF8, 32'h0000_0FF8});
   endtask

   // Read runs past the external size: zero fill
   task automatic t_read_oob;
      int n;
      int oob0;
      oob0 = oob_cnt;
      cfg_write(2'd0, 32'h0000_1020);
      cfg_write(2'd1, 32'hFF00_07F7);
      cfg_write(2'd2, 32'h0000_0018);
      count_busy(n);
      chk("R10 busy cycles 4", 64'(n), 64'd4);
      chk("R3 R5 in-range word 254", imem[4], xpat(254));
      chk("R5 in-range word 255", imem[5], xpat(255));
      chk("R5 zero fill 1", imem[6], 64'd0);
      chk("R5 zero fill 2", imem[7], 64'd0);
      chk("R5 no request past size", 64'(oob_cnt - oob0), 64'd0);
      chk("R3 R7 final ext addr", 64'(ext_addr_o), 64'h810);
      chk("R8 final local addr", 64'(lcl_addr_o), 64'h1040);
   endtask

   // Write runs past the external size: dropped
   task automatic t_write_oob;
      int n;
      int w0;
      int oob0;
      w0 = ext_wr_cnt;
      oob0 = oob_cnt;
      cfg_write(2'd0, 32'h0000_0320);
      cfg_write(2'd1, 32'h0000_07F8);
      cfg_write(2'd3, 32'h8000_0010);
      count_busy(n);
      chk("R10 busy cycles 3", 64'(n), 64'd3);
      chk("R6 last mapped word written", xmem[255], dpat(100));
      chk("R6 only one write strobe", 64'(ext_wr_cnt - w0), 64'd1);
      chk("R6 no request past size", 64'(oob_cnt - oob0), 64'd0);
      chk("R7 final ext addr", 64'(ext_addr_o), 64'h810);
      chk("R9 wr len spent", 64'(wr_len_o), 64'h8000_0FF8);
   endtask

   // Length write while busy is ignored
   task automatic t_busy_ignore;
      int n;
      int w0;
      logic [31:0] wr_mid;
      w0 = ext_wr_cnt;
      wr_mid = 32'h0;
      cfg_write(2'd0, 32'h0000_0640);
      cfg_write(2'd1, 32'h0000_0200);
      cfg_write(2'd2, 32'h0000_1038);
      n = 0;
      while (busy_o && n < 100000) begin
         n++;
         if (n == 3) begin
            cfg_we = 1'b1; cfg_sel = 2'd3; cfg_wdata = 32'h0000_0018;
         end else begin
            cfg_we = 1'b0;
         end
         if (n == 6) wr_mid = wr_len_o;
         @(negedge clk);
      end
      cfg_we = 1'b0;
      chk("R12 busy cycles unchanged", 64'(n), 64'd16);
      chk("R12 wr len held during run", 64'(wr_mid), 64'h8000_0FF8);
      chk("R12 no write started", 64'(ext_wr_cnt - w0), 64'd0);
      chk("R1 last word of row 2", dmem[215], xpat(79));
      chk("R8 final local addr", 64'(lcl_addr_o), 64'h6C0);
      chk("R7 final ext addr zero skip", 64'(ext_addr_o), 64'h280);
   endtask

   // Address writes are only pending until a length write
   task automatic t_pending;
      int n;
      cfg_write(2'd0, 32'h0000_0ABC);
      cfg_write(2'd1, 32'h0012_3458);
      repeat (4) @(negedge clk);
      chk("R11 no move started", 64'(busy_o), 64'd0);
      chk("R11 local addr unchanged", 64'(lcl_addr_o), 64'h6C0);
      chk("R11 ext addr unchanged", 64'(ext_addr_o), 64'h280);
      cfg_write(2'd2, 32'h0000_0000);
      count_busy(n);
      chk("R1 busy cycles single word", 64'(n), 64'd1);
      chk("R5 R11 zero from pending far address", dmem[343], 64'd0);
      chk("R11 final local addr", 64'(lcl_addr_o), 64'h0AC0);
      chk("R11 final ext addr", 64'(ext_addr_o), 64'h12_3460);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_read_rows();
      t_write_wrap();
      t_read_oob();
      t_write_oob();
      t_busy_ignore();
      t_pending();
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_vec++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule